// File: doc/BRIEF.md
# Omnipolar Two-Axis Magnetic Switch Decision Logic

This block is the digital back end of a two-axis magnetic switch. It steers the analog front end through four comparison phases: the X sensor, the X sensor with its polarity swapped, the Y sensor, and the Y sensor with its polarity swapped. For each phase, the comparator reports one bit. A low bit means the sensed magnitude in that orientation is above the threshold. The block keeps each phase's bit in a separate register. At the end of a full sweep it merges the four bits into a single active-low switch output. The switch therefore responds to a field at any in-plane angle and of either polarity.

Each axis contributes one pair term, and the term reports a trip only when exactly one bit of its pair is low. If both polarities of one axis read low together, the result is physically inconsistent and is not treated as a trip.

The block also produces the effective threshold code for the analog threshold generator. This code is the 4-bit trim code. When hysteresis is enabled, one selected trim bit is cleared while the switch is tripped, which lowers the release point below the operating point.

Top module: `omni_switch_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, `phase_sel` is 0, `sw_n` is 1 and `eff_code` is 0.
- R2: `phase_sel` encodes the active phase as 0 = X, 1 = inverted X, 2 = Y, 3 = inverted Y. It moves to the next value, wrapping 3 to 0, on every clock edge where `cmp_valid` is high, and holds otherwise.
- R3: On a clock edge with `cmp_valid` high, `cmp_bit` is stored as the result of the phase shown on `phase_sel`. Each phase has its own storage, so results A (phase 0), B (1), C (2) and D (3) are kept separately.
- R4: `sw_n` goes low when exactly one of A and B is low, or exactly one of C and D is low.
- R5: A pair whose two results are both low, or both high, does not cause a trip. With all four results low, `sw_n` stays high.
- R6: `eff_code` equals the trim code when `sw_n` is high, or when `hyst_sel[2]` is 1 (no hysteresis).
- R7: When `sw_n` is low and `hyst_sel[2]` is 0, `eff_code` equals the trim code with bit `hyst_sel[1:0]` forced to 0.
- R8: `sw_n` and `eff_code` change only on the clock edge that captures the phase 3 result. At that edge they are computed from the four stored results and from `trim_code` and `hyst_sel` as sampled then. At all other times they hold, including mid-sweep and while idle.
- R9: A single exceedance on the X pair and a single exceedance on the Y pair, present together, also give `sw_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Comparator result valid for the current phase |
| cmp_bit | input | 1 | Comparator result, low means exceedance |
| trim_code | input | 4 | Operating threshold trim code |
| hyst_sel | input | 3 | Bit 2 set: no hysteresis; else bits 1:0 pick the trim bit cleared while tripped |
| phase_sel | output | 2 | Front-end orientation select (R2 encoding) |
| sw_n | output | 1 | Active-low switch output |
| eff_code | output | 4 | Effective threshold code for the analog generator |

## Verification
Two things happen on the last strobe of a sweep. The phase 3 result is captured, and the switch decision and effective code are updated from that same bit. The decision therefore has to use the bit arriving on that edge, not the stale stored one. The bench provokes this with sweeps in which only D is low, and with sweeps in which D alone decides whether the Y pair trips. It then checks both outputs on the cycle after that strobe. A second overlap occurs when the trim code changes inside a sweep. The bench confirms that only the value present at the final strobe reaches `eff_code`.

// File: rtl/omni_switch_pkg.sv
package omni_switch_pkg;

    localparam int N_PHASE = 4;
    localparam int PH_W    = 2;

    typedef enum logic [PH_W-1:0] {
        PH_X  = 2'd0,
        PH_XN = 2'd1,
        PH_Y  = 2'd2,
        PH_YN = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

    typedef struct packed {
        logic [N_PHASE-1:0] res;
    } cap_state_t;

endpackage

// File: rtl/omni_phase_seq.sv
module omni_phase_seq
    import omni_switch_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_valid,
    output logic [PH_W-1:0] phase,
    output logic            sweep_done
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmp_valid) begin
            st_d.phase = phase_e'(st_q.phase + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_X};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = st_q.phase;
    assign sweep_done = cmp_valid && (st_q.phase == PH_YN);

    assert_phase_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> phase == $past(phase) + 2'd1);

    assert_phase_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(phase));

endmodule

// File: rtl/omni_result_bank.sv
module omni_result_bank
    import omni_switch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PH_W-1:0]    wr_idx,
    input  logic               wr_bit,
    output logic [N_PHASE-1:0] res_next
);

    cap_state_t st_d, st_q;

    for (genvar k = 0; k < N_PHASE; k++) begin : g_slot
        always_comb begin
            st_d.res[k] = st_q.res[k];
            if (wr_en && (wr_idx == PH_W'(k))) begin
                st_d.res[k] = wr_bit;
            end
        end

        assert_slot_capture_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == PH_W'(k)) |=> st_q.res[k] == $past(wr_bit));

        assert_slot_keep_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == PH_W'(k)) |=> $stable(st_q.res[k]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{res: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_next = st_d.res;

endmodule

// File: rtl/omni_decide.sv
module omni_decide
    import omni_switch_pkg::*;
#(
    parameter int CODE_W = 4,
    localparam int IDX_W  = $clog2(CODE_W),
    localparam int HSEL_W = IDX_W + 1
) (
    input  logic [N_PHASE-1:0] res,
    input  logic [CODE_W-1:0]  trim,
    input  logic [HSEL_W-1:0]  hsel,
    output logic               sw_n,
    output logic [CODE_W-1:0]  code
);

    localparam int N_AXIS = N_PHASE / 2;

    logic [N_AXIS-1:0] pair_ok;
    logic [CODE_W-1:0] hyst_mask;

    for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
        // pair ok when both polarities agree; a lone low result trips
        assign pair_ok[a] = ~(res[2*a] ^ res[2*a+1]);
    end

    assign sw_n = &pair_ok;

    for (genvar i = 0; i < CODE_W; i++) begin : g_mask
        assign hyst_mask[i] = !hsel[HSEL_W-1] && (hsel[IDX_W-1:0] == IDX_W'(i));
    end

    always_comb begin
        code = trim;
        if (!sw_n) begin
            code = trim & ~hyst_mask;
        end
    end

endmodule

// File: rtl/omni_switch_core.sv
module omni_switch_core
    import omni_switch_pkg::*;
#(
    parameter int CODE_W = 4,
    localparam int HSEL_W = $clog2(CODE_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic              cmp_bit,
    input  logic [CODE_W-1:0] trim_code,
    input  logic [HSEL_W-1:0] hyst_sel,
    output logic [PH_W-1:0]   phase_sel,
    output logic              sw_n,
    output logic [CODE_W-1:0] eff_code
);

    typedef struct packed {
        logic              sw;
        logic [CODE_W-1:0] code;
    } out_state_t;

    out_state_t out_d, out_q;

    logic               sweep_done;
    logic [N_PHASE-1:0] res_next;
    logic               dec_sw;
    logic [CODE_W-1:0]  dec_code;

    omni_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_valid  (cmp_valid),
        .phase      (phase_sel),
        .sweep_done (sweep_done)
    );

    omni_result_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmp_valid),
        .wr_idx   (phase_sel),
        .wr_bit   (cmp_bit),
        .res_next (res_next)
    );

    omni_decide #(.CODE_W(CODE_W)) u_dec (
        .res  (res_next),
        .trim (trim_code),
        .hsel (hyst_sel),
        .sw_n (dec_sw),
        .code (dec_code)
    );

    always_comb begin
        out_d = out_q;
        if (sweep_done) begin
            out_d.sw   = dec_sw;
            out_d.code = dec_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{sw: 1'b1, code: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign sw_n     = out_q.sw;
    assign eff_code = out_q.code;

    assert_out_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_done |=> ($stable(sw_n) && $stable(eff_code)));

    assert_released_code_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> (!sw_n || eff_code == $past(trim_code)));

    assert_tripped_subset_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> ((eff_code & ~$past(trim_code)) == '0));

endmodule

// File: tb/omni_switch_core_tb.sv
module omni_switch_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_valid = 1'b0;
    logic       cmp_bit = 1'b1;
    logic [3:0] trim_code = 4'd0;
    logic [2:0] hyst_sel = 3'b100;
    logic [1:0] phase_sel;
    logic       sw_n;
    logic [3:0] eff_code;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    omni_switch_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_bit   (cmp_bit),
        .trim_code (trim_code),
        .hyst_sel  (hyst_sel),
        .phase_sel (phase_sel),
        .sw_n      (sw_n),
        .eff_code  (eff_code)
    );

    // {results A B C D, trim, hyst_sel, expected sw_n, expected eff_code}
    localparam int NVEC = 11;
    localparam logic [15:0] VEC [NVEC] = '{
        {4'b1111, 4'b1010, 3'b100, 1'b1, 4'b1010},  // R6 idle field
        {4'b0111, 4'b1111, 3'b000, 1'b0, 4'b1110},  // R4 R7 A low
        {4'b1011, 4'b1111, 3'b011, 1'b0, 4'b0111},  // R4 R7 B low
        {4'b1101, 4'b0110, 3'b010, 1'b0, 4'b0010},  // R4 R7 C low
        {4'b1110, 4'b0110, 3'b100, 1'b0, 4'b0110},  // R4 R6 D low, none
        {4'b0011, 4'b1111, 3'b000, 1'b1, 4'b1111},  // R5 X both low
        {4'b1100, 4'b1001, 3'b011, 1'b1, 4'b1001},  // R5 Y both low
        {4'b0110, 4'b1101, 3'b001, 1'b0, 4'b1101},  // R9 both axes
        {4'b0000, 4'b0101, 3'b000, 1'b1, 4'b0101},  // R5 all low
        {4'b0010, 4'b1011, 3'b001, 1'b0, 4'b1001},  // R4 R7 Y single
        {4'b1111, 4'b0000, 3'b111, 1'b1, 4'b0000}   // R6 zero code
    };

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic strobe(input logic b);
        cmp_valid = 1'b1;
        cmp_bit   = b;
        @(negedge clk);
        cmp_valid = 1'b0;
        cmp_bit   = 1'b1;
    endtask

    task automatic sweep(input logic [3:0] r, input logic [3:0] trim, input logic [2:0] hs);
        trim_code = trim;
        hyst_sel  = hs;
        for (int i = 0; i < 4; i++) begin
            check(phase_sel, i, "R2 phase order");
            strobe(r[3-i]);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(phase_sel, 0, "R1 reset phase");
        check(sw_n, 1, "R1 reset sw_n");
        check(eff_code, 0, "R1 reset code");
        rst_n = 1'b1;
        @(negedge clk);
        check(phase_sel, 0, "R1 phase after release");
        check(sw_n, 1, "R1 sw_n after release");

        for (int v = 0; v < NVEC; v++) begin
            sweep(VEC[v][15:12], VEC[v][11:8], VEC[v][7:5]);
            check(sw_n, VEC[v][4], "R4 R5 R9 switch decision");
            check(eff_code, VEC[v][3:0], "R6 R7 effective code");
            check(phase_sel, 0, "R2 wrap to X");
        end

        // Trip, then idle: outputs and phase hold (R8, R2)
        sweep(4'b0111, 4'b1111, 3'b010);
        check(sw_n, 0, "R4 trip before idle");
        check(eff_code, 4'b1011, "R7 code bit2 cleared");
        trim_code = 4'b0001;
        hyst_sel  = 3'b100;
        repeat (5) @(negedge clk);
        check(sw_n, 0, "R8 idle hold sw_n");
        check(eff_code, 4'b1011, "R8 idle hold code");
        check(phase_sel, 0, "R2 idle hold phase");

        // Partial sweep with gaps; trim changes before last strobe (R8, R3)
        trim_code = 4'b0011;
        strobe(1'b1);
        @(negedge clk);
        strobe(1'b1);
        check(phase_sel, 2, "R2 mid sweep phase");
        check(sw_n, 0, "R8 mid sweep hold sw_n");
        check(eff_code, 4'b1011, "R8 mid sweep hold code");
        strobe(1'b1);
        repeat (2) @(negedge clk);
        trim_code = 4'b1100;
        hyst_sel  = 3'b011;
        strobe(1'b1);
        check(sw_n, 1, "R3 release after clean sweep");
        check(eff_code, 4'b1100, "R8 trim sampled at last strobe");

        // D alone decides on the last edge (R3, R4)
        sweep(4'b1110, 4'b1111, 3'b000);
        check(sw_n, 0, "R3 fresh D bit used");
        check(eff_code, 4'b1110, "R7 bit0 cleared");

        // Results from an earlier sweep are overwritten, not merged (R3)
        sweep(4'b1111, 4'b1111, 3'b000);
        check(sw_n, 1, "R3 old results replaced");
        check(eff_code, 4'b1111, "R6 released full code");

        // Reset in mid sweep (R1)
        sweep(4'b1011, 4'b0111, 3'b000);
        check(sw_n, 0, "R4 trip before reset");
        strobe(1'b0);
        strobe(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(phase_sel, 0, "R1 mid sweep reset phase");
        check(sw_n, 1, "R1 mid sweep reset sw_n");
        check(eff_code, 0, "R1 mid sweep reset code");
        rst_n = 1'b1;
        @(negedge clk);
        sweep(4'b1111, 4'b0100, 3'b100);
        check(sw_n, 1, "R1 clean sweep after reset");
        check(eff_code, 4'b0100, "R6 code after reset");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule